// File: doc/BRIEF.md
# Banked UART Register Front End

This block is the bus-facing register layer of a 16550-style serial port. It sits on a simple 32-bit peripheral bus with byte addresses and offers a data window, an auxiliary window, a control register and a status register. Behind the data window sit two 16-entry byte queues. The transmit queue is filled by bus writes and drained by a future serializer through a valid/ready read port. The receive queue is filled by a future deserializer through a valid/ready write port and drained by bus reads. The block also contains the 16x baud tick generator, which runs from the bus clock.

A single latch bit in the control register switches the banks. With the latch bit clear, the data window reaches the queues. With it set, the data window and the auxiliary window become the low and high bytes of a 16-bit baud divisor. Each received byte is queued together with its parity, framing and break flags. The status register always reports the flags of the byte that the next data read will return. Software therefore reads status first and then pops the byte.

Top module: `uart_banked_regs`

## Requirements
- R1: After reset the control register (offset 0xC) reads 0x03, the divisor reads 0x0001, the status register (offset 0x14) reads 0x20, `tx_valid` is 0, `rx_ready` is 1 and `baud_tick` is high every cycle.
- R2: With the latch bit clear, a read at offset 0x0 returns the oldest receive byte in bits 7:0 with bits 31:8 zero, and removes that byte. Bytes leave in arrival order.
- R3: With the latch bit clear, a write at offset 0x0 queues bits 7:0 of the write data for transmission and ignores bits 31:8. `tx_data` presents the bytes in write order, and bit 0 is the first bit to go on the line.
- R4: With the latch bit set, offset 0x0 reads and writes divisor bits 7:0 and offset 0x4 reads and writes divisor bits 15:8. Neither access touches either queue.
- R5: With the latch bit clear, offset 0x4 reads zero and writes to it change nothing.
- R6: The status register has bit 0 = receive byte available, bit 2 = parity error, bit 3 = framing error, bit 4 = break, and bit 5 = transmit queue empty. The flags belong to the head receive entry and read as zero when the receive queue is empty. Reading status has no side effect.
- R7: A data read from an empty receive queue returns zero and leaves the queue unchanged.
- R8: The transmit queue holds 16 bytes. A write to a full queue is dropped.
- R9: The receive queue holds 16 entries. `rx_ready` is low while it is full, and offered entries are not taken.
- R10: Control bits 1:0 select the word length 5 + value. A received byte is stored with the bits above that length forced to zero.
- R11: For a divisor N, `baud_tick` is high for one cycle in the N-th cycle after the edge that writes either divisor byte, and then every N cycles.
- R12: A divisor of 0x0000 behaves as 0x0001, so `baud_tick` is high every cycle.
- R13: Control bit 7 is the latch bit. The control register reads back bit 7 and bits 1:0, and the other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest transmit byte, bit 0 sent first |
| tx_ready | input | 1 | Serializer takes `tx_data` |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_data | input | 8 | Received byte, bit 0 received first |
| rx_par_err | input | 1 | Parity error for the offered byte |
| rx_frm_err | input | 1 | Framing error for the offered byte |
| rx_brk | input | 1 | Break condition for the offered byte |
| rx_ready | output | 1 | Receive queue can take an entry |
| baud_tick | output | 1 | One-cycle pulse at 16x the baud rate |

## Verification
A misplaced queue pointer shows up at the next data read or at the next `tx_data` handshake as a wrong byte, or a byte returned twice or skipped. A lost fill count shows up as `rx_ready` or status bit 5 being wrong in the same cycle. A flag stored against the wrong entry appears in the status read just before the matching data read. A wrong bank decode shows up within one access as a divisor write that queues a byte or a data read that returns a divisor byte. A counter fault in the tick generator appears as a first pulse in the wrong cycle after the divisor write, or as a gap that is not N.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_AUX  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h14;

    typedef struct packed {
        logic              brk;
        logic              frm_err;
        logic              par_err;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic       latch;
        logic [1:0] wlen;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{latch: 1'b0, wlen: 2'b11};
    localparam logic [DIV_W-1:0] DIV_RESET = 16'h0001;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DATA,
        ACC_AUX,
        ACC_DIVLO,
        ACC_DIVHI,
        ACC_CTRL,
        ACC_STAT
    } acc_e;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : d;
    endfunction

    function automatic logic [BYTE_W-1:0] len_mask(input logic [1:0] wlen);
        return 8'hFF >> (2'd3 - wlen);
    endfunction

endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PTR_W:0] wp, rp;
    logic do_push, do_pop;

    assign empty   = (wp == rp);
    assign full    = (wp[PTR_W] != rp[PTR_W]) && (wp[PTR_W-1:0] == rp[PTR_W-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp[PTR_W-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
    import uart_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             reload,
    output logic             tick
);
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign lim    = clamp_div(divisor);
    assign at_end = (cnt >= lim - 1'b1);
    assign tick   = at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (reload || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  rx_entry_t         rx_head,
    input  logic              rx_empty,
    input  logic              tx_empty,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_push_data,
    output logic              rx_pop,
    output logic [DIV_W-1:0]  divisor,
    output logic              div_reload,
    output logic              latch,
    output logic [1:0]        wlen
);
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    acc_e             acc;
    logic             rd, wr;
    rx_entry_t        flags;

    assign rd = bus_en && !bus_we;
    assign wr = bus_en && bus_we;

    always_comb begin
        case (bus_addr)
            OFS_DATA: acc = ctrl_q.latch ? ACC_DIVLO : ACC_DATA;
            OFS_AUX:  acc = ctrl_q.latch ? ACC_DIVHI : ACC_AUX;
            OFS_CTRL: acc = ACC_CTRL;
            OFS_STAT: acc = ACC_STAT;
            default:  acc = ACC_NONE;
        endcase
    end

    assign tx_push      = wr && (acc == ACC_DATA);
    assign tx_push_data = bus_wdata[BYTE_W-1:0];
    assign rx_pop       = rd && (acc == ACC_DATA);
    assign div_reload   = wr && ((acc == ACC_DIVLO) || (acc == ACC_DIVHI));
    assign divisor      = div_q;
    assign latch        = ctrl_q.latch;
    assign wlen         = ctrl_q.wlen;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            div_q  <= DIV_RESET;
        end else if (wr) begin
            case (acc)
                ACC_CTRL:  ctrl_q <= '{latch: bus_wdata[7], wlen: bus_wdata[1:0]};
                ACC_DIVLO: div_q[7:0] <= bus_wdata[7:0];
                ACC_DIVHI: div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
                default: ;
            endcase
        end
    end

    assign flags = rx_empty ? '0 : rx_head;

    always_comb begin
        bus_rdata = '0;
        case (acc)
            ACC_DATA:  bus_rdata[BYTE_W-1:0] = flags.data;
            ACC_DIVLO: bus_rdata[7:0] = div_q[7:0];
            ACC_DIVHI: bus_rdata[7:0] = div_q[DIV_W-1:8];
            ACC_CTRL:  bus_rdata[7:0] = {ctrl_q.latch, 5'b0, ctrl_q.wlen};
            ACC_STAT:  bus_rdata[5:0] = {tx_empty, flags.brk, flags.frm_err,
                                         flags.par_err, 1'b0, !rx_empty};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_banked_regs.sv
module uart_banked_regs
    import uart_regs_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    output logic              rx_ready,
    output logic              baud_tick
);
    localparam int RX_W = $bits(rx_entry_t);

    logic              tx_push, tx_empty, tx_full;
    logic [BYTE_W-1:0] tx_push_data;
    logic              rx_pop, rx_empty, rx_full;
    rx_entry_t         rx_in, rx_head;
    logic [RX_W-1:0]   rx_head_bits;
    logic [DIV_W-1:0]  divisor;
    logic              div_reload, latch;
    logic [1:0]        wlen;

    uart_reg_bank bank_i (
        .clk          (clk),
        .rst          (rst),
        .bus_en       (bus_en),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rx_head      (rx_head),
        .rx_empty     (rx_empty),
        .tx_empty     (tx_empty),
        .tx_push      (tx_push),
        .tx_push_data (tx_push_data),
        .rx_pop       (rx_pop),
        .divisor      (divisor),
        .div_reload   (div_reload),
        .latch        (latch),
        .wlen         (wlen)
    );

    uart_sync_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) tx_q_i (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_valid && tx_ready),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );
    assign tx_valid = !tx_empty;

    assign rx_in = '{brk: rx_brk, frm_err: rx_frm_err, par_err: rx_par_err,
                     data: rx_data & len_mask(wlen)};

    uart_sync_fifo #(.W(RX_W), .DEPTH(RX_DEPTH)) rx_q_i (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_valid && !rx_full),
        .push_data (rx_in),
        .pop       (rx_pop),
        .head      (rx_head_bits),
        .empty     (rx_empty),
        .full      (rx_full)
    );
    assign rx_head  = rx_entry_t'(rx_head_bits);
    assign rx_ready = !rx_full;

    uart_tick_gen tick_i (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .reload  (div_reload),
        .tick    (baud_tick)
    );

endmodule

// File: rtl/uart_banked_regs_chk.sv
module uart_banked_regs_chk
    import uart_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              latch,
    input logic              rx_empty,
    input logic              rx_full,
    input logic              rx_ready,
    input logic              tx_full,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DIV_W-1:0]  divisor,
    input logic              div_reload,
    input logic              baud_tick
);
    logic data_rd, data_wr;
    assign data_rd = bus_en && !bus_we && (bus_addr == OFS_DATA);
    assign data_wr = bus_en && bus_we && (bus_addr == OFS_DATA);

    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        data_rd |-> (bus_rdata[31:8] == '0)); // R2

    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !latch && rx_empty) |-> (bus_rdata == '0)); // R7

    AST_LATCH_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (data_wr && latch && !tx_valid) |=> !tx_valid); // R4

    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !(tx_valid && tx_ready)) |=> tx_full); // R8

    AST_RX_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !(data_rd && !latch)) |=> !rx_ready); // R9

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && (divisor > 16'd1) && !div_reload) |=> !baud_tick); // R11

    AST_ZERO_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (divisor == '0) |-> baud_tick); // R12

endmodule

bind uart_banked_regs uart_banked_regs_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .latch      (latch),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .rx_ready   (rx_ready),
    .tx_full    (tx_full),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .divisor    (divisor),
    .div_reload (div_reload),
    .baud_tick  (baud_tick)
);

// File: tb/uart_banked_regs_tb_top.sv
module uart_banked_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, baud_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_banked_regs dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_ready(rx_ready),
        .baud_tick(baud_tick)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] d, input logic p, input logic f, input logic b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_brk = b;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic tx_take(output logic v, output logic [7:0] d);
        @(negedge clk);
        v = tx_valid; d = tx_data; tx_ready = 1'b1;
        @(posedge clk); #1;
        tx_ready = 1'b0;
    endtask

    task automatic tick_scan(input int n, output int first, output int cnt);
        first = -1; cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (baud_tick) begin
                if (first < 0) first = i;
                cnt++;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] r; int f, c;
        @(negedge clk);
        check("R1 tx_valid", {31'b0, tx_valid}, 0);
        check("R1 rx_ready", {31'b0, rx_ready}, 1);
        tick_scan(4, f, c);
        check("R1 tick every cycle", c, 4);
        bus_rd(5'h0C, r); check("R1 ctrl", r, 32'h03);
        bus_rd(5'h14, r); check("R1 status", r, 32'h20);
        bus_wr(5'h0C, 32'h83);
        bus_rd(5'h00, r); check("R1 div low", r, 32'h01);
        bus_rd(5'h04, r); check("R1 div high", r, 32'h00);
        bus_wr(5'h0C, 32'h03);
    endtask

    task automatic t_rx_order();
        logic [31:0] r;
        rx_put(8'h11, 1, 0, 0);
        rx_put(8'h22, 0, 1, 0);
        rx_put(8'h33, 0, 0, 1);
        bus_rd(5'h14, r); check("R6 status parity head", r, 32'h25);
        bus_rd(5'h00, r); check("R2 first byte", r, 32'h11);
        bus_rd(5'h14, r); check("R6 status framing head", r, 32'h29);
        bus_rd(5'h14, r); check("R6 status read no pop", r, 32'h29);
        bus_rd(5'h00, r); check("R2 second byte", r, 32'h22);
        bus_rd(5'h14, r); check("R6 status break head", r, 32'h31);
        bus_rd(5'h00, r); check("R2 third byte", r, 32'h33);
        bus_rd(5'h14, r); check("R6 status empty", r, 32'h20);
    endtask

    task automatic t_rx_empty();
        logic [31:0] r;
        bus_rd(5'h00, r); check("R7 empty read zero", r, 32'h0);
        bus_rd(5'h14, r); check("R7 status after empty read", r, 32'h20);
        rx_put(8'h5A, 0, 0, 0);
        bus_rd(5'h00, r); check("R7 byte after empty read", r, 32'h5A);
        bus_rd(5'h00, r); check("R7 empty again", r, 32'h0);
    endtask

    task automatic t_rx_full();
        logic [31:0] r;
        for (int i = 0; i < 16; i++) rx_put(8'(i * 3 + 1), 0, 0, 0);
        @(negedge clk);
        check("R9 rx_ready low when full", {31'b0, rx_ready}, 0);
        rx_put(8'hEE, 1, 1, 1);
        for (int i = 0; i < 16; i++) begin
            bus_rd(5'h00, r); check("R9 full queue order", r, 32'(8'(i * 3 + 1)));
        end
        bus_rd(5'h00, r); check("R9 extra entry not taken", r, 32'h0);
    endtask

    task automatic t_wlen();
        logic [31:0] r;
        for (int l = 0; l < 4; l++) begin
            bus_wr(5'h0C, 32'(l));
            bus_rd(5'h0C, r); check("R13 ctrl readback", r, 32'(l));
            rx_put(8'hFF, 0, 0, 0);
            bus_rd(5'h00, r); check("R10 word length mask", r, 32'(8'hFF >> (3 - l)));
        end
    endtask

    task automatic t_tx();
        logic [31:0] r; logic v; logic [7:0] d;
        bus_wr(5'h00, 32'hDEADBEA5);
        bus_rd(5'h14, r); check("R6 tx not empty", r, 32'h00);
        tx_take(v, d);
        check("R3 tx valid", {31'b0, v}, 1);
        check("R3 tx low byte only", {24'b0, d}, 32'hA5);
        for (int i = 0; i < 16; i++) bus_wr(5'h00, 32'h40 + i);
        bus_wr(5'h00, 32'hEE);
        for (int i = 0; i < 16; i++) begin
            tx_take(v, d);
            check("R8 tx order when full", {23'b0, v, d}, 32'h100 | (32'h40 + i));
        end
        @(negedge clk);
        check("R8 write to full dropped", {31'b0, tx_valid}, 0);
        bus_rd(5'h14, r); check("R6 tx empty", r, 32'h20);
    endtask

    task automatic t_bank();
        logic [31:0] r;
        rx_put(8'h77, 0, 0, 0);
        bus_wr(5'h0C, 32'h83);
        bus_rd(5'h0C, r); check("R13 latch readback", r, 32'h83);
        bus_wr(5'h00, 32'hFFFFFF34);
        bus_wr(5'h04, 32'h12);
        bus_rd(5'h00, r); check("R4 div low", r, 32'h34);
        bus_rd(5'h04, r); check("R4 div high", r, 32'h12);
        @(negedge clk);
        check("R4 no tx push", {31'b0, tx_valid}, 0);
        bus_wr(5'h0C, 32'h03);
        bus_rd(5'h04, r); check("R5 aux reads zero", r, 32'h0);
        bus_wr(5'h04, 32'hFF);
        bus_rd(5'h04, r); check("R5 aux write ignored", r, 32'h0);
        bus_rd(5'h14, r); check("R4 rx kept", r, 32'h21);
        bus_rd(5'h00, r); check("R4 rx byte intact", r, 32'h77);
        bus_wr(5'h0C, 32'h83);
        bus_rd(5'h04, r); check("R5 divisor untouched", r, 32'h12);
        bus_wr(5'h0C, 32'h03);
    endtask

    task automatic t_tick();
        int f, c;
        bus_wr(5'h0C, 32'h83);
        bus_wr(5'h04, 32'h00);
        bus_wr(5'h00, 32'h05);
        tick_scan(15, f, c);
        check("R11 first tick N=5", f, 4);
        check("R11 tick count N=5", c, 3);
        bus_wr(5'h00, 32'h00);
        tick_scan(8, f, c);
        check("R12 zero divisor first", f, 0);
        check("R12 zero divisor every cycle", c, 8);
        bus_wr(5'h04, 32'h01);
        bus_wr(5'h00, 32'h03);
        tick_scan(3 * 259, f, c);
        check("R11 first tick N=259", f, 258);
        check("R11 tick count N=259", c, 3);
        bus_wr(5'h0C, 32'h03);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_rx_order();
        t_rx_empty();
        t_rx_full();
        t_wlen();
        t_tx();
        t_bank();
        t_tick();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule